// File: doc/BRIEF.md
# SMM entry state-save sequencer

This block performs the entry half of a system management mode transition for a simple 32-bit processor model. It waits for a management interrupt request while idle. When it accepts the request, it drives its active-low acknowledge output low and captures the twelve architectural registers presented on its inputs in that same clock edge. It then writes those registers as 32-bit words through a valid/ready memory write port. The words go to fixed slots inside the 512-byte save area that hangs below the programmable base plus FFFFh.

After the last word has been accepted, the block raises a load strobe for one cycle. The strobe carries the register values a handler starts from: a cleaned-up CR0, fixed EFLAGS, DR7, instruction pointer and code segment, and zero for every data segment. The general-purpose, descriptor-table, task and DR6 registers are not driven. The acknowledge stays low until an exit input is sampled after the load strobe. That exit returns the block to idle.

Top module: `smm_entry_seq`

## Requirements
- R1: After reset, smiact_n is 1 and wr_valid, load_stb and done are 0.
- R2: A high smi_req sampled while idle is accepted at that clock edge. From the next cycle smiact_n is 0 and wr_valid is 1.
- R3: Exactly twelve stores are made, at wr_addr = smm_base + zero-extended 16-bit offset. The order is CR0 at FFFCh, CR3 at FFF8h, EFLAGS at FFF4h, EIP at FFF0h, EDI at FFECh, ESI at FFE8h, EBP at FFE4h, ESP at FFE0h, EBX at FFDCh, EDX at FFD8h, ECX at FFD4h and EAX at FFD0h.
- R4: Each stored word is the input value present at the accepting clock edge. Input changes after that edge do not reach the stored data.
- R5: A store is made only when wr_valid and wr_ready are both high. Address and data hold steady while wr_ready is low. wr_be is 4'b1111 on every store.
- R6: load_stb is high for exactly one cycle, the cycle after the twelfth store is accepted. In that cycle new_eflags = 0000_0002h, new_dr7 = 0000_0400h, new_eip = 0000_8000h, new_cs = 0003_0000h and new_dseg = 0.
- R7: During load_stb, new_cr0 equals the captured CR0 with bits 0, 2, 3 and 31 cleared; every other bit is kept.
- R8: done rises in the cycle after load_stb. It stays high while smi_req is high and falls in the cycle after smi_req is seen low.
- R9: While smiact_n is 0, smi_req is ignored: no further stores are issued and no load strobe occurs.
- R10: smiact_n stays 0 until exit_i is sampled high after the load strobe. exit_i during the save phase is ignored. An accepted exit sets smiact_n to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | Management interrupt request |
| exit_i | input | 1 | Leave management mode (honoured after the load strobe) |
| smm_base | input | 32 | Base address of the management memory region |
| cur_cr0 | input | 32 | Live CR0 |
| cur_cr3 | input | 32 | Live CR3 |
| cur_eflags | input | 32 | Live EFLAGS |
| cur_eip | input | 32 | Live instruction pointer |
| cur_edi | input | 32 | Live EDI |
| cur_esi | input | 32 | Live ESI |
| cur_ebp | input | 32 | Live EBP |
| cur_esp | input | 32 | Live ESP |
| cur_ebx | input | 32 | Live EBX |
| cur_edx | input | 32 | Live EDX |
| cur_ecx | input | 32 | Live ECX |
| cur_eax | input | 32 | Live EAX |
| smiact_n | output | 1 | Active-low acknowledge, low while in management mode |
| wr_valid | output | 1 | Store request valid |
| wr_ready | input | 1 | Store request accepted by memory |
| wr_addr | output | 32 | Store byte address |
| wr_data | output | 32 | Store data word |
| wr_be | output | 4 | Store byte enables |
| load_stb | output | 1 | One-cycle strobe to load entry values |
| new_cr0 | output | 32 | CR0 value to load |
| new_eflags | output | 32 | EFLAGS value to load |
| new_eip | output | 32 | Instruction pointer to load |
| new_dr7 | output | 32 | DR7 value to load |
| new_cs | output | 32 | Code segment value to load |
| new_dseg | output | 32 | Value for DS, ES, FS, GS and SS |
| done | output | 1 | Entry complete, held while request stays high |

## Verification
The hold-while-stalled assertion assumes that smm_base does not change between acceptance of a request and the last store. It makes this assumption because the write address is built combinationally from that input. The bench changes smm_base only while the block is idle. It changes the register inputs freely during the save phase, which exercises the capture rule. wr_ready is driven from a fixed pattern or from a pseudo-random pattern, and is never forced high beyond what a memory could do. The bench pulses exit_i both inside and outside the save phase so that the ignore rule is exercised.

// File: rtl/smm_entry_seq.sv
module smm_entry_seq #(
  parameter int unsigned DW     = 32,
  parameter int unsigned OW     = 16,
  parameter logic [15:0] TOP_OFS = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smi_req,
  input  logic          exit_i,
  input  logic [31:0]   smm_base,
  input  logic [31:0]   cur_cr0,
  input  logic [31:0]   cur_cr3,
  input  logic [31:0]   cur_eflags,
  input  logic [31:0]   cur_eip,
  input  logic [31:0]   cur_edi,
  input  logic [31:0]   cur_esi,
  input  logic [31:0]   cur_ebp,
  input  logic [31:0]   cur_esp,
  input  logic [31:0]   cur_ebx,
  input  logic [31:0]   cur_edx,
  input  logic [31:0]   cur_ecx,
  input  logic [31:0]   cur_eax,
  output logic          smiact_n,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [31:0]   wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_be,
  output logic          load_stb,
  output logic [31:0]   new_cr0,
  output logic [31:0]   new_eflags,
  output logic [31:0]   new_eip,
  output logic [31:0]   new_dr7,
  output logic [31:0]   new_cs,
  output logic [31:0]   new_dseg,
  output logic          done
);

  localparam int unsigned NSLOT = 12;
  localparam int unsigned IW    = $clog2(NSLOT);
  localparam logic [DW-1:0] CR0_CLR = 32'h8000_000D;

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_LOAD, S_HELD} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   snap [NSLOT];
  logic [DW-1:0]   cur  [NSLOT];
  logic [OW-1:0]   ofs;
  logic            accept, fire;

  always_comb begin
    cur[0]  = cur_cr0;  cur[1]  = cur_cr3;  cur[2]  = cur_eflags; cur[3]  = cur_eip;
    cur[4]  = cur_edi;  cur[5]  = cur_esi;  cur[6]  = cur_ebp;    cur[7]  = cur_esp;
    cur[8]  = cur_ebx;  cur[9]  = cur_edx;  cur[10] = cur_ecx;    cur[11] = cur_eax;
  end

  assign accept   = (st == S_IDLE) && smi_req;
  assign wr_valid = (st == S_SAVE);
  assign fire     = wr_valid && wr_ready;
  assign ofs      = TOP_OFS - OW'({idx, 2'b00});
  assign wr_addr  = smm_base + 32'(ofs);
  assign wr_data  = snap[idx];
  assign wr_be    = 4'b1111;

  assign load_stb   = (st == S_LOAD);
  assign new_cr0    = snap[0] & ~CR0_CLR;
  assign new_eflags = 32'h0000_0002;
  assign new_dr7    = 32'h0000_0400;
  assign new_eip    = 32'h0000_8000;
  assign new_cs     = 32'h0003_0000;
  assign new_dseg   = 32'h0;

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < NSLOT; i++) snap[i] <= cur[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      smiact_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_SAVE;
          idx      <= '0;
          smiact_n <= 1'b0;
        end
        S_SAVE: if (fire) begin
          if (idx == IW'(NSLOT - 1)) st <= S_LOAD;
          else idx <= idx + 1'b1;
        end
        S_LOAD: begin
          st   <= S_HELD;
          done <= 1'b1;
        end
        S_HELD: begin
          if (!smi_req) done <= 1'b0;
          if (exit_i) begin
            st       <= S_IDLE;
            smiact_n <= 1'b1;
            done     <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == smm_base[1:0] && wr_be == 4'b1111);

  p_load_after_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(wr_valid && wr_ready));

  p_load_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  p_done_in_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !smiact_n);

  p_ack_before_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !smiact_n);

  p_ack_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smiact_n && !done && !exit_i |=> !smiact_n);

endmodule

// File: tb/smm_entry_seq_tb_top.sv
`timescale 1ns/1ps
module smm_entry_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, smi_req, exit_i, wr_ready;
  logic [31:0] smm_base;
  logic [31:0] v [12];
  logic        smiact_n, wr_valid, load_stb, done;
  logic [31:0] wr_addr, wr_data, new_cr0, new_eflags, new_eip, new_dr7, new_cs, new_dseg;
  logic [3:0]  wr_be;

  smm_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .exit_i(exit_i), .smm_base(smm_base),
    .cur_cr0(v[0]), .cur_cr3(v[1]), .cur_eflags(v[2]), .cur_eip(v[3]),
    .cur_edi(v[4]), .cur_esi(v[5]), .cur_ebp(v[6]), .cur_esp(v[7]),
    .cur_ebx(v[8]), .cur_edx(v[9]), .cur_ecx(v[10]), .cur_eax(v[11]),
    .smiact_n(smiact_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .load_stb(load_stb), .new_cr0(new_cr0), .new_eflags(new_eflags), .new_eip(new_eip),
    .new_dr7(new_dr7), .new_cs(new_cs), .new_dseg(new_dseg), .done(done));

  int tests = 0, fails = 0, nloads = 0;
  logic [63:0] exp_q [$];
  logic [31:0] exp_cr0;
  bit          rdy_rand = 0;
  bit          prev_stall = 0, prev_load = 0;
  logic [31:0] st_addr, st_data;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_entry();
    for (int i = 0; i < 12; i++)
      exp_q.push_back({smm_base + 32'(16'hFFFC - 16'(4 * i)), v[i]});
    exp_cr0 = v[0] & ~32'h8000_000D;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    #1;
    wr_ready <= rdy_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(wr_valid && wr_addr == st_addr, "R5 stalled address held", wr_addr, st_addr);
        chk(wr_data == st_data, "R5 stalled data held", wr_data, st_data);
      end
      prev_stall = wr_valid && !wr_ready;
      st_addr = wr_addr; st_data = wr_data;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected store", wr_addr, 32'hx);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(wr_addr == e[63:32], "R3 store address", wr_addr, e[63:32]);
          chk(wr_data == e[31:0], "R4 store data", wr_data, e[31:0]);
          chk(wr_be == 4'hF, "R5 byte enables", 32'(wr_be), 32'hF);
        end
      end
      if (load_stb) begin
        nloads++;
        chk(!prev_load, "R6 strobe single cycle", 32'(prev_load), 0);
        chk(exp_q.size() == 0, "R6 strobe after last store", exp_q.size(), 0);
        chk(new_cr0 == exp_cr0, "R7 cr0 clear", new_cr0, exp_cr0);
        chk(new_eflags == 32'h2, "R6 eflags", new_eflags, 32'h2);
        chk(new_dr7 == 32'h400, "R6 dr7", new_dr7, 32'h400);
        chk(new_eip == 32'h8000, "R6 eip", new_eip, 32'h8000);
        chk(new_cs == 32'h3_0000, "R6 cs", new_cs, 32'h3_0000);
        chk(new_dseg == 0, "R6 data segments", new_dseg, 0);
      end
      prev_load = load_stb;
    end
  end

  task automatic run_entry(input logic [31:0] base, input logic [31:0] seed, input bit exit_mid);
    int start, guard;
    smm_base = base;
    for (int i = 0; i < 12; i++) v[i] = seed ^ (32'h1111_1111 * 32'(i + 1));
    push_entry();
    smi_req = 1;
    tick();
    @(negedge clk);
    chk(!smiact_n, "R2 acknowledge low", 32'(smiact_n), 0);
    chk(wr_valid, "R2 store valid", 32'(wr_valid), 1);
    for (int i = 0; i < 12; i++) v[i] = ~v[i];
    if (exit_mid) begin
      tick(); exit_i = 1; tick(); exit_i = 0;
      @(negedge clk);
      chk(!smiact_n, "R10 exit during save ignored", 32'(smiact_n), 0);
    end
    start = nloads; guard = 0;
    while (nloads == start && guard < 500) begin @(negedge clk); guard++; end
    chk(nloads == start + 1, "R6 strobe seen", nloads, start + 1);
    @(negedge clk);
    chk(done, "R8 done after strobe", 32'(done), 1);
    tick(); tick();
    chk(done, "R8 done held", 32'(done), 1);
    smi_req = 0; tick();
    @(negedge clk);
    chk(!done, "R8 done cleared", 32'(done), 0);
    start = nloads;
    smi_req = 1;
    for (int k = 0; k < 5; k++) begin
      tick(); @(negedge clk);
      chk(!wr_valid && !smiact_n, "R9 request ignored in mode", 32'(wr_valid), 0);
    end
    chk(nloads == start, "R9 no extra strobe", nloads, start);
    smi_req = 0; tick();
    chk(!smiact_n, "R10 held until exit", 32'(smiact_n), 0);
    exit_i = 1; tick(); exit_i = 0;
    @(negedge clk);
    chk(smiact_n, "R10 exit releases", 32'(smiact_n), 1);
    chk(exp_q.size() == 0, "R3 twelve stores", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 0; smi_req = 0; exit_i = 0; smm_base = 0; wr_ready = 1;
    for (int i = 0; i < 12; i++) v[i] = 0;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk(smiact_n, "R1 reset acknowledge", 32'(smiact_n), 1);
    chk(!wr_valid, "R1 reset valid", 32'(wr_valid), 0);
    chk(!load_stb, "R1 reset strobe", 32'(load_stb), 0);
    chk(!done, "R1 reset done", 32'(done), 0);
    tick();
    run_entry(32'h0003_0000, 32'hA5A5_0F0F, 0);
    rdy_rand = 1;
    run_entry(32'h000A_0000, 32'h1234_5678, 1);
    run_entry(32'hFFFF_0000, 32'hFFFF_FFFF, 0);
    rdy_rand = 0;
    run_entry(32'h0000_0000, 32'h8000_000D, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL ALL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule